// File: doc/BRIEF.md
# Programmable I/O Select Decoder

This block watches a 24-bit bus address and produces the value of one shared strobe pin together with a flag that sorts each address as internal or external space. The pin has two functions. As an address strobe it goes low during every bus cycle that reaches external space. As an I/O select it goes low only when a bus cycle falls inside a small window that always starts at 0xFFF000. The window size is picked by a two-bit range code.

The internal regions are module parameters: on-chip ROM, on-chip RAM and the internal register block with its reserved area. Any address outside all of them is external. The RAM region counts as internal only while RAM is enabled. When RAM is disabled, the same addresses decode as external space.

The three control inputs (select enable, range code, RAM enable) are captured into a configuration register on every clock. While reset is held, and until the first clock after reset is released, the configuration takes safe defaults: pin in address-strobe mode, largest window, RAM enabled. Address and cycle decoding are combinational, so the pin follows the bus cycle for its whole length.

Top module: `ios_decoder`

## Requirements
- R1: While reset is held `strobe_n` is 1. Until the first rising clock after reset is released, the configuration is pin function = address strobe, range code = 3 and RAM enabled, whatever the control inputs are.
- R2: In address-strobe mode (registered `sel_enable` = 0), `strobe_n` is 0 exactly when `bus_cycle` is 1 and `ext_space` is 1.
- R3: In I/O-select mode (registered `sel_enable` = 1), `strobe_n` is 0 exactly when `bus_cycle` is 1, the address is external, and the address lies from 0xFFF000 up to a last address set by `sel_range`: code 0 ends at 0xFFF03F, code 1 at 0xFFF0FF, code 2 at 0xFFF3FF and code 3 at 0xFFF7FF.
- R4: With `bus_cycle` = 0, `strobe_n` is 1 in both modes.
- R5: Addresses in the ROM region (default 0x000000–0x00FFFF) and in the internal register region (default 0xFFF800–0xFFFFFF) give `ext_space` = 0. All addresses outside every internal region give `ext_space` = 1.
- R6: Addresses in the RAM region (default 0xFFE080–0xFFEFFF) give `ext_space` = 0 when the registered RAM enable is 1, and `ext_space` = 1 when it is 0.
- R7: A change on `sel_enable`, `sel_range` or `ram_enable` affects the outputs only after the next rising clock.
- R8: While `bus_cycle`, the address and the configuration are held, `strobe_n` keeps its value on every clock of a multi-clock bus cycle.
- R9: The window base is fixed. Address 0xFFEFFF, one below the base, never asserts the I/O select, whatever the range code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 24 | Bus address of the current access |
| bus_cycle | input | 1 | High while a bus cycle is in progress |
| ram_enable | input | 1 | 1 = RAM region is internal, 0 = RAM region is external |
| sel_enable | input | 1 | 1 = pin works as I/O select, 0 = pin works as address strobe |
| sel_range | input | 2 | Window size code (0..3) |
| strobe_n | output | 1 | Shared pin value, active low |
| ext_space | output | 1 | 1 when the address decodes to external space |

## Verification
A wrong configuration bit would show up within one clock as the wrong pin function or the wrong window. An address-strobe low on an in-window access would then look like a select that has come loose, or a RAM access would be flagged external. The bench therefore tests every range code at its last address and at the address one above it, and it tests the window base from below, so a wrong window mask shows on the same cycle it is applied. A missing or extra configuration register stage shows at the one step where new control values are presented together with an access, since the expected result is built from the values of the previous clock.

// File: rtl/ios_pkg.sv
package ios_pkg;

    typedef logic [23:0] addr_t;

    typedef struct packed {
        logic       sel_en;
        logic [1:0] range;
        logic       ram_en;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{sel_en: 1'b0, range: 2'd3, ram_en: 1'b1};

    // log2 of the window size for a range code: 64, 256, 1024, 2048 bytes
    function automatic int win_log2(input int code);
        return (code < 3) ? (6 + 2 * code) : 11;
    endfunction

    // inclusive range test without a constant compare against zero
    function automatic logic in_span(input addr_t a, input addr_t lo, input addr_t hi);
        return (a - lo) <= (hi - lo);
    endfunction

endpackage

// File: rtl/ios_space_map.sv
module ios_space_map
    import ios_pkg::*;
#(
    parameter addr_t ROM_LO = 24'h000000,
    parameter addr_t ROM_HI = 24'h00FFFF,
    parameter addr_t RAM_LO = 24'hFFE080,
    parameter addr_t RAM_HI = 24'hFFEFFF,
    parameter addr_t REG_LO = 24'hFFF800,
    parameter addr_t REG_HI = 24'hFFFFFF
) (
    input  addr_t addr,
    input  logic  ram_en,
    output logic  ext_o
);
    logic in_rom, in_ram, in_reg;

    always_comb begin
        in_rom = in_span(addr, ROM_LO, ROM_HI);
        in_ram = in_span(addr, RAM_LO, RAM_HI);
        in_reg = in_span(addr, REG_LO, REG_HI);
        ext_o  = !(in_rom || in_reg || (in_ram && ram_en));
    end
endmodule

// File: rtl/ios_window.sv
module ios_window
    import ios_pkg::*;
#(
    parameter addr_t WIN_BASE = 24'hFFF000,
    parameter int    CODES    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  addr_t                      addr,
    input  logic [$clog2(CODES)-1:0]   code,
    output logic                       hit_o
);
    localparam int AW = $bits(addr_t);

    logic [CODES-1:0] hit_v;

    for (genvar gi = 0; gi < CODES; gi++) begin : g_code
        localparam int LG = win_log2(gi);
        assign hit_v[gi] = (addr[AW-1:LG] == WIN_BASE[AW-1:LG]);
    end

    assign hit_o = hit_v[code];

    // R9: a hit never lies below the fixed base
    p_base_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (addr >= WIN_BASE));
endmodule

// File: rtl/ios_pin_mux.sv
module ios_pin_mux (
    input  logic hold,
    input  logic sel_en,
    input  logic cyc,
    input  logic ext,
    input  logic hit,
    output logic strobe_n
);
    logic as_low, sel_low;

    always_comb begin
        as_low   = cyc && ext;
        sel_low  = cyc && ext && hit;
        strobe_n = hold ? 1'b1 : !(sel_en ? sel_low : as_low);
    end
endmodule

// File: rtl/ios_decoder.sv
module ios_decoder
    import ios_pkg::*;
#(
    parameter addr_t ROM_LO   = 24'h000000,
    parameter addr_t ROM_HI   = 24'h00FFFF,
    parameter addr_t RAM_LO   = 24'hFFE080,
    parameter addr_t RAM_HI   = 24'hFFEFFF,
    parameter addr_t REG_LO   = 24'hFFF800,
    parameter addr_t REG_HI   = 24'hFFFFFF,
    parameter addr_t WIN_BASE = 24'hFFF000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] bus_addr,
    input  logic        bus_cycle,
    input  logic        ram_enable,
    input  logic        sel_enable,
    input  logic [1:0]  sel_range,
    output logic        strobe_n,
    output logic        ext_space
);
    cfg_t cfg_d, cfg_q;
    logic hit;

    always_comb begin
        cfg_d        = cfg_q;
        cfg_d.sel_en = sel_enable;
        cfg_d.range  = sel_range;
        cfg_d.ram_en = ram_enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    ios_space_map #(
        .ROM_LO(ROM_LO), .ROM_HI(ROM_HI),
        .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
        .REG_LO(REG_LO), .REG_HI(REG_HI)
    ) u_map (
        .addr   (bus_addr),
        .ram_en (cfg_q.ram_en),
        .ext_o  (ext_space)
    );

    ios_window #(.WIN_BASE(WIN_BASE), .CODES(4)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .code  (cfg_q.range),
        .hit_o (hit)
    );

    ios_pin_mux u_mux (
        .hold     (!rst_n),
        .sel_en   (cfg_q.sel_en),
        .cyc      (bus_cycle),
        .ext      (ext_space),
        .hit      (hit),
        .strobe_n (strobe_n)
    );

    // R4: no strobe outside a bus cycle
    p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cycle |-> strobe_n);

    // R2: address strobe follows every external cycle
    p_as_external_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.sel_en && bus_cycle && ext_space) |-> !strobe_n);

    // R3: an I/O select low only ever marks an external access
    p_sel_external_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.sel_en && !strobe_n) |-> ext_space);

    // R6: enabled RAM never decodes as external
    p_ram_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ram_en && in_span(bus_addr, RAM_LO, RAM_HI)) |-> !ext_space);

    // R7: configuration is the control value of the previous clock
    p_cfg_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cfg_q.range == $past(sel_range) && cfg_q.sel_en == $past(sel_enable)));
endmodule

// File: tb/ios_decoder_test.sv
module ios_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = 24'h0;
    logic        bus_cycle = 1'b0;
    logic        ram_enable = 1'b1;
    logic        sel_enable = 1'b0;
    logic [1:0]  sel_range = 2'd3;
    logic        strobe_n, ext_space;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  strobe;
        logic  ext;
        string tag;
    } exp_t;
    exp_t sb[$];

    // model of the registered configuration
    logic       m_sel = 1'b0;
    logic [1:0] m_rng = 2'd3;
    logic       m_ram = 1'b1;
    bit         done = 0;

    always #2 clk = ~clk;   // 250 MHz

    ios_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cycle(bus_cycle),
        .ram_enable(ram_enable), .sel_enable(sel_enable), .sel_range(sel_range),
        .strobe_n(strobe_n), .ext_space(ext_space)
    );

    function automatic logic model_ext(input logic [23:0] a, input logic ram);
        logic internal;
        internal = (a <= 24'h00FFFF) || (a >= 24'hFFF800)
                || (ram && a >= 24'hFFE080 && a <= 24'hFFEFFF);
        return !internal;
    endfunction

    function automatic logic model_strobe(input logic [23:0] a, input logic cyc,
                                          input logic sel, input logic [1:0] rng,
                                          input logic ram);
        int size;
        logic e, h;
        size = (rng == 2'd0) ? 64 : (rng == 2'd1) ? 256 : (rng == 2'd2) ? 1024 : 2048;
        e = model_ext(a, ram);
        h = (a >= 24'hFFF000) && (int'(a) < 32'hFFF000 + size);
        return !(cyc && (sel ? (e && h) : e));
    endfunction

    // drives one clock of stimulus; expected values come from the model config
    task automatic step(input logic sel, input logic [1:0] rng, input logic ram,
                        input logic [23:0] a, input logic cyc, input string tag);
        exp_t x;
        @(posedge clk);
        #1;
        sel_enable = sel; sel_range = rng; ram_enable = ram;
        bus_addr = a; bus_cycle = cyc;
        x.strobe = model_strobe(a, cyc, m_sel, m_rng, m_ram);
        x.ext    = model_ext(a, m_ram);
        x.tag    = tag;
        sb.push_back(x);
        m_sel = sel; m_rng = rng; m_ram = ram;
    endtask

    // monitor: samples mid-cycle, after the driver
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                checks++;
                if (strobe_n !== x.strobe || ext_space !== x.ext) begin
                    fails++;
                    $display("FAIL %s: strobe_n=%b ext_space=%b expected strobe_n=%b ext_space=%b",
                             x.tag, strobe_n, ext_space, x.strobe, x.ext);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: strobe high during reset with an external cycle presented
        sel_enable = 1'b1; sel_range = 2'd0; ram_enable = 1'b0;
        bus_addr = 24'hFFF100; bus_cycle = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (strobe_n !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset: strobe_n=%b expected 1", strobe_n);
        end
        // R1: defaults hold until the first clock after release
        rst_n = 1'b1;
        #2;
        checks++;
        if (strobe_n !== 1'b0 || ext_space !== 1'b1) begin
            fails++;
            $display("FAIL R1 defaults: strobe_n=%b ext_space=%b expected 0 1", strobe_n, ext_space);
        end
        m_sel = 1'b1; m_rng = 2'd0; m_ram = 1'b0;

        // R3: I/O select, code 0, then each code at last address and one above
        step(1, 2'd0, 0, 24'hFFF100, 1, "R3 code0 above");
        step(1, 2'd0, 0, 24'hFFF03F, 1, "R3 code0 last");
        step(1, 2'd1, 0, 24'hFFF040, 1, "R7 old code0 above");
        step(1, 2'd1, 0, 24'hFFF0FF, 1, "R3 code1 last");
        step(1, 2'd1, 0, 24'hFFF100, 1, "R3 code1 above");
        step(1, 2'd2, 0, 24'hFFF000, 1, "R3 base");
        step(1, 2'd2, 0, 24'hFFF3FF, 1, "R3 code2 last");
        step(1, 2'd2, 0, 24'hFFF400, 1, "R3 code2 above");
        step(1, 2'd3, 0, 24'hFFF400, 1, "R7 old code2");
        step(1, 2'd3, 0, 24'hFFF7FF, 1, "R3 code3 last");
        step(1, 2'd3, 0, 24'hFFF800, 1, "R3 code3 above");
        // R9: below base, RAM disabled so address is external
        step(1, 2'd3, 0, 24'hFFEFFF, 1, "R9 below base");
        step(1, 2'd0, 0, 24'hFFEFFF, 1, "R9 below base code3");
        step(1, 2'd0, 0, 24'hFFEFFF, 1, "R9 below base code0");
        // R4: idle in both modes
        step(1, 2'd3, 0, 24'hFFF010, 0, "R4 idle select");
        step(0, 2'd3, 0, 24'h123456, 1, "R7 old select mode");
        step(0, 2'd3, 0, 24'h123456, 0, "R4 idle strobe");
        // R2: address strobe on external spaces, not on internal ones
        step(0, 2'd3, 0, 24'h123456, 1, "R2 external");
        step(0, 2'd3, 0, 24'hFFF010, 1, "R2 window external");
        // R5: ROM and register regions
        step(0, 2'd3, 0, 24'h000000, 1, "R5 rom low");
        step(0, 2'd3, 0, 24'h00FFFF, 1, "R5 rom high");
        step(0, 2'd3, 0, 24'h010000, 1, "R5 after rom");
        step(0, 2'd3, 0, 24'hFFFF80, 1, "R5 register");
        step(0, 2'd3, 0, 24'hFFF7FF, 1, "R5 below register");
        // R6: RAM enable switch
        step(0, 2'd3, 0, 24'hFFE800, 1, "R6 ram disabled");
        step(0, 2'd3, 1, 24'hFFE800, 1, "R7 old ram disabled");
        step(0, 2'd3, 1, 24'hFFE800, 1, "R6 ram enabled");
        step(0, 2'd3, 1, 24'hFFE080, 1, "R6 ram first");
        step(0, 2'd3, 1, 24'hFFE07F, 1, "R6 below ram");
        // R8: multi-clock cycles held in both modes
        for (int i = 0; i < 3; i++) step(0, 2'd3, 1, 24'h400000, 1, "R8 strobe held");
        step(1, 2'd1, 1, 24'hFFF080, 1, "R8 switch");
        for (int i = 0; i < 3; i++) step(1, 2'd1, 1, 24'hFFF080, 1, "R8 select held");
        for (int i = 0; i < 3; i++) step(1, 2'd1, 1, 24'hFFF180, 1, "R8 select out held");

        @(posedge clk);
        bus_cycle = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule